// File: doc/BRIEF.md
# CAN Bus Fault Qualifier and Interrupt Flags

This block sits behind the analog bus monitors of a CAN transceiver. It takes seven raw fault-class indications, each from a comparator outside the block, and one sampled "bus is dominant" level. A raw indication becomes a recorded fault only if it is still asserted through four long dominant-to-recessive transitions of the bus. A dominant phase is long if it lasts at least a minimum time, counted in system clocks. Each recorded fault sets a sticky bit in an 8-bit status register. An enable register masks the status bits, and the OR of the masked bits drives a level interrupt.

Software reaches both registers through a small synchronous register port. A read is requested with a one-cycle strobe, and the data is registered. Status bits are cleared by writing one to them. The enable register is read/write. The port has no back-pressure: every strobe is accepted in the cycle it is presented. The raw fault inputs and the dominant input are asynchronous to the block clock, so each passes through a two-flop synchronizer before it is used.

Top module: `can_fault_flags`

## Requirements
- R1: A fault class is recorded in its status bit on the fourth qualifying dominant-to-recessive transition seen while its synchronized raw input is high. Three such transitions leave the bit at 0.
- R2: A transition qualifies when the synchronized dominant phase before it lasted at least MIN_US*CLKS_PER_US clocks. A phase of exactly that length qualifies. A shorter phase returns every class's count to zero.
- R3: If a class's synchronized raw input goes low, that class's count returns to zero, and counting restarts from zero when the input rises again.
- R4: Raw input bit i maps to status bit i: 6 one termination open, 5 CANH shorted to CANL, 4 CANH shorted to battery, 3 CANL shorted to ground, 2 bus open, 1 ground short, 0 battery short. Bit 7 of both registers always reads 0.
- R5: Writing to address 8'h54 clears each status bit written with 1. Bits written with 0 keep their value.
- R6: If a fault is recorded in the same cycle that a write-one-to-clear targets the same bit, the bit ends up set.
- R7: After reset, status reads 8'h00, enable reads 8'h7F, and irq is 0.
- R8: irq is high exactly when some status bit and its enable bit are both 1, and it stays high until those bits are cleared or disabled.
- R9: A read strobe on address 8'h54 returns status and on 8'h59 returns enable, on reg_rdata one clock later. Any other address returns 8'h00. Writes to 8'h59 update enable bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_raw | input | 7 | Raw per-class fault indications, asynchronous |
| bus_dom | input | 1 | Sampled bus dominant level, asynchronous |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Level interrupt |

## Verification
A class counter stuck, or reset at the wrong moment, shows at the ports as a status bit that sets one transition early or late, or never sets. This is visible at the first status read after the fourth long transition. A wrong compare on the dominant-phase length shows only when the phase is one clock short of the minimum or exactly at it, so the bench drives both lengths. A wrong priority between set and clear shows only when a clear lands in the very cycle a bit is recorded. That case is driven and read back a few cycles later.

// File: rtl/canff_pkg.sv
package canff_pkg;
  localparam int NUM_CLASS = 7;
  localparam int REG_W     = 8;
  localparam logic [7:0] ADDR_STATUS = 8'h54;
  localparam logic [7:0] ADDR_ENABLE = 8'h59;
  localparam logic [NUM_CLASS-1:0] ENABLE_RST = 7'h7F;

  typedef enum logic [2:0] {
    CLS_BATT_SHORT = 3'd0,
    CLS_GND_SHORT  = 3'd1,
    CLS_BUS_OPEN   = 3'd2,
    CLS_L_GND      = 3'd3,
    CLS_H_BATT     = 3'd4,
    CLS_H_TO_L     = 3'd5,
    CLS_HALF_TERM  = 3'd6
  } fault_class_e;
endpackage

// File: rtl/canff_sync.sv
module canff_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/canff_dom_timer.sv
module canff_dom_timer #(
  parameter int MIN_CLKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dom_s,
  output logic qual_edge,
  output logic short_edge
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CLKS);

  logic [CW-1:0] len_q;
  logic          dom_q;
  logic          fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      dom_q <= 1'b0;
    end else begin
      dom_q <= dom_s;
      if (!dom_s)          len_q <= '0;
      else if (len_q != SAT) len_q <= len_q + 1'b1;
    end
  end

  assign fall       = dom_q & ~dom_s;
  assign qual_edge  = fall & (len_q == SAT);
  assign short_edge = fall & (len_q != SAT);
endmodule

// File: rtl/canff_qual_ctr.sv
module canff_qual_ctr #(
  parameter int EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_s,
  input  logic qual_edge,
  input  logic short_edge,
  output logic set_o
);
  localparam int CW = (EDGES > 1) ? $clog2(EDGES) : 1;
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [CW-1:0] cnt;

  assign set_o = raw_s & qual_edge & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!raw_s || short_edge) cnt <= '0;
    else if (set_o)                cnt <= '0;
    else if (qual_edge)            cnt <= cnt + 1'b1;
  end

  // R3: a dropped raw indication empties the count
  a_r3_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_s |=> (cnt == '0));
  // R2: a short dominant phase empties the count
  a_r2_short_clears: assert property (@(posedge clk) disable iff (!rst_n)
    short_edge |=> (cnt == '0));
  // R1: after recording, counting restarts from zero
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> (cnt == '0));
endmodule

// File: rtl/canff_flag_regs.sv
module canff_flag_regs
  import canff_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CLASS-1:0] set_i,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 reg_rd,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);
  logic [NUM_CLASS-1:0] status;
  logic [NUM_CLASS-1:0] enable;
  logic                 wr_st, wr_en;
  logic [NUM_CLASS-1:0] clr_mask;

  assign wr_st    = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_en    = reg_wr && (reg_addr == ADDR_ENABLE);
  assign clr_mask = wr_st ? reg_wdata[NUM_CLASS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= ENABLE_RST;
    end else begin
      status <= (status & ~clr_mask) | set_i;
      if (wr_en) enable <= reg_wdata[NUM_CLASS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_STATUS: reg_rdata <= {1'b0, status};
        ADDR_ENABLE: reg_rdata <= {1'b0, enable};
        default:     reg_rdata <= '0;
      endcase
    end
  end

  assign irq = |(status & enable);

  // R5: bits written with one and not being set are gone next cycle
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> ((status & $past(reg_wdata[NUM_CLASS-1:0] & ~set_i)) == '0));
  // R6: a recorded fault always lands, even under a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status & $past(set_i)) == $past(set_i)));
  // R5: without a status write no bit falls
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> ((status & $past(status)) == $past(status)));
  // R8: the interrupt only drops through a register write
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);
endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags
  import canff_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int MIN_US      = 2,
  parameter int EDGES       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CLASS-1:0] fault_raw,
  input  logic                 bus_dom,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 reg_rd,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);
  localparam int MIN_CLKS = MIN_US * CLKS_PER_US;

  logic [NUM_CLASS:0]   sync_out;
  logic [NUM_CLASS-1:0] raw_s;
  logic                 dom_s;
  logic                 qual_edge, short_edge;
  logic [NUM_CLASS-1:0] set_v;

  canff_sync #(.W(NUM_CLASS + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_dom, fault_raw}), .q(sync_out));

  assign raw_s = sync_out[NUM_CLASS-1:0];
  assign dom_s = sync_out[NUM_CLASS];

  canff_dom_timer #(.MIN_CLKS(MIN_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .dom_s(dom_s),
    .qual_edge(qual_edge), .short_edge(short_edge));

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_cls
    canff_qual_ctr #(.EDGES(EDGES)) u_ctr (
      .clk(clk), .rst_n(rst_n), .raw_s(raw_s[i]),
      .qual_edge(qual_edge), .short_edge(short_edge), .set_o(set_v[i]));
  end

  canff_flag_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(set_v),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq));

  // R2: a transition is either long or short, never both
  a_r2_edge_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({qual_edge, short_edge}) <= 1);
endmodule

// File: tb/can_fault_flags_bench.sv
module can_fault_flags_bench;
  localparam int CPU = 4;
  localparam int MUS = 2;
  localparam int MINC = CPU * MUS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] fault_raw = '0;
  logic       bus_dom = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  can_fault_flags #(.CLKS_PER_US(CPU), .MIN_US(MUS), .EDGES(4)) u_can_fault_flags (
    .clk(clk), .rst_n(rst_n), .fault_raw(fault_raw), .bus_dom(bus_dom),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq));

  typedef struct packed {
    logic [6:0] raw;
    logic [7:0] len;
    logic [3:0] n;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{7'h01, 8'(MINC),     4'd4, 8'h01},
    '{7'h40, 8'(MINC),     4'd4, 8'h40},
    '{7'h24, 8'(MINC + 3), 4'd4, 8'h24},
    '{7'h08, 8'(MINC),     4'd3, 8'h00},
    '{7'h10, 8'(MINC - 1), 4'd4, 8'h00},
    '{7'h7F, 8'(MINC),     4'd5, 8'h7F},
    '{7'h02, 8'(MINC),     4'd4, 8'h02},
    '{7'h18, 8'(MINC + 1), 4'd2, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulses(input int len, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); bus_dom = 1'b1;
      repeat (len) @(negedge clk);
      bus_dom = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_raw(input logic [6:0] r);
    @(negedge clk); fault_raw = r;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset values
    rd(8'h54, rv); check("R7 status reset", rv, 8'h00);
    rd(8'h59, rv); check("R7 enable reset", rv, 8'h7F);
    check("R7 irq reset", {7'd0, irq}, 8'h00);
    // R9 unmapped address
    rd(8'h00, rv); check("R9 unmapped read", rv, 8'h00);

    // vector table: R1 R2 R4
    foreach (VEC[i]) begin
      set_raw(VEC[i].raw);
      pulses(int'(VEC[i].len), int'(VEC[i].n));
      rd(8'h54, rv);
      check($sformatf("R1/R2/R4 vector %0d status", i), rv, VEC[i].exp);
      check($sformatf("R8 vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].exp != 0});
      set_raw(7'h00);
      wr(8'h54, 8'hFF);
    end

    // R3 raw drop restarts counting
    set_raw(7'h04); pulses(MINC, 2);
    set_raw(7'h00); set_raw(7'h04);
    pulses(MINC, 2);
    rd(8'h54, rv); check("R3 drop then 2 more", rv, 8'h00);
    pulses(MINC, 2);
    rd(8'h54, rv); check("R3 four after restart", rv, 8'h04);
    set_raw(7'h00); wr(8'h54, 8'hFF);

    // R2 short phase in the middle resets
    set_raw(7'h20); pulses(MINC, 2); pulses(MINC - 1, 1); pulses(MINC, 3);
    rd(8'h54, rv); check("R2 short mid-run", rv, 8'h00);
    pulses(MINC, 1);
    rd(8'h54, rv); check("R2 fourth after short", rv, 8'h20);

    // R5 write zero keeps, write one clears
    wr(8'h54, 8'h00);
    rd(8'h54, rv); check("R5 write zero keeps", rv, 8'h20);
    set_raw(7'h00);
    wr(8'h54, 8'h20);
    rd(8'h54, rv); check("R5 write one clears", rv, 8'h00);
    check("R8 irq after clear", {7'd0, irq}, 8'h00);

    // R9 R4 enable write/readback, bit 7 reads 0
    wr(8'h59, 8'hFE);
    rd(8'h59, rv); check("R9 enable readback", rv, 8'h7E);
    // R8 masked bit raises no irq
    set_raw(7'h01); pulses(MINC, 4); set_raw(7'h00);
    rd(8'h54, rv); check("R8 masked status", rv, 8'h01);
    check("R8 masked irq low", {7'd0, irq}, 8'h00);
    wr(8'h59, 8'h7F);
    check("R8 enable raises irq", {7'd0, irq}, 8'h01);
    wr(8'h54, 8'hFF);

    // R6 set and clear in same cycle
    set_raw(7'h10); pulses(MINC, 3);
    @(negedge clk); bus_dom = 1'b1;
    repeat (MINC) @(negedge clk);
    bus_dom = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_addr = 8'h54; reg_wdata = 8'h10; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(8'h54, rv); check("R6 set beats clear", rv, 8'h10);
    check("R6 irq held", {7'd0, irq}, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule